// File: doc/BRIEF.md
# Serial Nibble Register Control Port

This block is a serial slave that lets a host read and write a bank of seven 4-bit control registers over four wires: an active-low frame enable, a serial clock, a serial data input and a serial data output with its own output-enable. Each frame is eight serial clocks long. Data is taken in on rising serial clock edges and launched on falling ones, most significant bit first. The first bit gives the direction (0 for write, 1 for read). The next three bits give the register address. The last four bits carry the data nibble.

The port runs on the chip's system clock. The three serial inputs are synchronised and edge-detected inside the port, so each serial clock phase must last at least `SYNC_STAGES + 2` system clocks. The serial output pad is outside the block: it drives `sdo` when `sdo_oe` is high and is high impedance otherwise. Each register bit is either writable or read-only, as set by a mask parameter. A read-only bit always shows the matching bit of `status_in`, and writes never change it. The full register view is also presented on `reg_q` for use by the rest of the chip.

Top module: `nibble_ctl_port`

## Requirements
- R1: A frame starts when `csn` falls. The first four rising `sclk` edges after that carry the direction bit, then address bits A2, A1, A0.
- R2: With direction 0, the next four rising edges carry data bits D3..D0. After the eighth edge, that nibble is stored in the writable bits of the addressed register.
- R3: With direction 1, D3..D0 of the addressed register appear on `sdo` after the falling edges that follow rising edges 4, 5, 6 and 7. The host samples each bit on the next rising edge.
- R4: `sdo_oe` is high only between the falling edge after rising edge 4 and rising edge 8 of a read frame. It is low in write frames, in the address phase and between frames.
- R5: While `sdo_oe` is high, `sdi` is ignored, and a read frame changes no register.
- R6: Bits set in `RO_MASK` are read-only. Writes leave them unchanged, and reads and `reg_q` return `status_in` for them. Register i occupies bits [4i+3:4i] of `RO_MASK`, `status_in` and `reg_q`. By default, register 6 is fully read-only, bits 3:2 of register 5 are read-only, and all other bits are writable.
- R7: Address 7 holds no register. A write to it changes nothing, and a read of it returns 0000.
- R8: If `csn` rises before the eighth rising edge, the frame is dropped with no register update. `sdo_oe` falls within `SYNC_STAGES + 2` system clocks, and the next frame decodes from bit 0.
- R9: After reset, the writable bits hold `RST_VAL` (default per register 0..6: 1, C, 3, 5, A, 0, 0) and `sdo_oe` is low.
- R10: Rising `sclk` edges after the eighth one in a frame, before `csn` rises, are ignored. They neither change a register nor enable the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csn | input | 1 | Frame enable, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the pad |
| sdo_oe | output | 1 | Pad drive enable for `sdo` |
| status_in | input | NUM_REGS*DATA_W | Values shown in read-only bits |
| reg_q | output | NUM_REGS*DATA_W | Current register view |

## Verification
The bench writes all sixteen nibbles to all eight addresses and reads each one back. It compares every read against a register model that honours the read-only masks, so a leak through a mask, or a write that lands on address 7, shows up as a mismatch. It drops frames after every possible bit count from one to seven; a port that commits a partial frame or keeps a stale bit count would corrupt a register or misdecode the next frame. It also sends extra clocks after bit eight and toggles `sdi` during read data. An off-by-one in the phase counter would show up as a wrong write or a read nibble shifted by one bit, and an output enable held at the wrong time would be caught at the sample points.

// File: rtl/scp_pkg.sv
// Package: shared types for the serial nibble control port.
// Assumes: one frame = 1 direction bit + address + data nibble.
package scp_pkg;

    // Frame phase of the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // Direction bit encoding.
    localparam logic DIR_WRITE = 1'b0;
    localparam logic DIR_READ  = 1'b1;

endpackage

// File: rtl/scp_sync_edge.sv
// Module: scp_sync_edge
// Synchronises one asynchronous input into the system clock domain and
// reports its rising and falling edges as single-cycle pulses.
// Assumes: the input stays stable for at least STAGES+2 clocks per level.
module scp_sync_edge #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic rise,
    output logic fall
);

    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    // Shift the raw input through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= {PIPE_W{INIT}};
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], din};
        end
    end

    // Present the synchronised level and its edges.
    always_comb begin
        dout = pipe_q[STAGES-1];
        rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end

endmodule

// File: rtl/scp_frame_ctrl.sv
// Module: scp_frame_ctrl
// Frame sequencer: shifts in the direction/address header and the write
// nibble on serial rising edges, shifts read data out on falling edges,
// drives the output enable and issues a one-cycle write strobe.
// Assumes: edge pulses come from scp_sync_edge; csn high aborts any frame.
module scp_frame_ctrl
    import scp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              csn_fall,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int CMD_BITS = 1 + ADDR_W;
    localparam int MAX_BITS = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
    localparam int CNT_W    = $clog2(MAX_BITS) + 1;

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CMD_BITS-1:0] cmd_sr_q;
    logic [CMD_BITS-1:0] cmd_next;
    logic [DATA_W-1:0] rx_sr_q;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] tx_sr_q;
    logic              is_read_q;
    logic              tx_pend_q;

    // Next header and write-data words including the bit now on sdi.
    always_comb begin
        cmd_next = {cmd_sr_q[CMD_BITS-2:0], sdi_s};
        rx_next  = {rx_sr_q[DATA_W-2:0], sdi_s};
    end

    // Frame phase, bit counter, header capture and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            cmd_sr_q  <= '0;
            rx_sr_q   <= '0;
            is_read_q <= 1'b0;
            addr      <= '0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (csn_s) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        if (csn_fall) begin
                            phase_q <= PH_CMD;
                            cnt_q   <= '0;
                        end
                    end
                    PH_CMD: begin
                        if (sclk_rise) begin
                            cmd_sr_q <= cmd_next;
                            if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
                                phase_q   <= PH_DATA;
                                cnt_q     <= '0;
                                is_read_q <= (cmd_next[CMD_BITS-1] == DIR_READ);
                                addr      <= cmd_next[ADDR_W-1:0];
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (sclk_rise) begin
                            if (!is_read_q) begin
                                rx_sr_q <= rx_next;
                            end
                            if (cnt_q == CNT_W'(DATA_W - 1)) begin
                                phase_q <= PH_DONE;
                                cnt_q   <= '0;
                                if (!is_read_q) begin
                                    wr_en   <= 1'b1;
                                    wr_data <= rx_next;
                                end
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    PH_DONE: begin
                        cnt_q <= '0;
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                    end
                endcase
            end
        end
    end

    // Read path: capture the register once, then shift it out on falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr_q   <= '0;
            tx_pend_q <= 1'b0;
            sdo       <= 1'b0;
            sdo_oe    <= 1'b0;
        end else begin
            if (csn_s) begin
                tx_pend_q <= 1'b0;
                sdo_oe    <= 1'b0;
            end else if (phase_q == PH_CMD && sclk_rise &&
                         cnt_q == CNT_W'(CMD_BITS - 1) &&
                         cmd_next[CMD_BITS-1] == DIR_READ) begin
                tx_pend_q <= 1'b1;
            end else if (tx_pend_q) begin
                tx_sr_q   <= rd_data;
                tx_pend_q <= 1'b0;
            end else if (phase_q == PH_DATA && is_read_q) begin
                if (sclk_fall) begin
                    sdo     <= tx_sr_q[DATA_W-1];
                    tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
                    sdo_oe  <= 1'b1;
                end else if (sclk_rise && cnt_q == CNT_W'(DATA_W - 1)) begin
                    sdo_oe <= 1'b0;
                end
            end else begin
                sdo_oe <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/scp_nibble_bank.sv
// Module: scp_nibble_bank
// Bank of NUM_REGS nibble registers. Writable bits are stored here;
// read-only bits show the matching status input. Addresses at or above
// NUM_REGS read as zero and ignore writes.
// Assumes: wr_en is a single-cycle strobe.
module scp_nibble_bank #(
    parameter int                         NUM_REGS = 7,
    parameter int                         ADDR_W   = 3,
    parameter int                         DATA_W   = 4,
    parameter logic [NUM_REGS*DATA_W-1:0] RO_MASK  = '0,
    parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL  = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [NUM_REGS*DATA_W-1:0]   status_in,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_REGS*DATA_W-1:0]   reg_q
);

    logic [DATA_W-1:0] view [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam logic [DATA_W-1:0] RO  = RO_MASK[gi*DATA_W +: DATA_W];
        localparam logic [DATA_W-1:0] RV  = RST_VAL[gi*DATA_W +: DATA_W];
        logic [DATA_W-1:0] store_q;

        // Hold the writable bits of this register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q <= RV & ~RO;
            end else if (wr_en && addr == ADDR_W'(gi)) begin
                store_q <= wr_data & ~RO;
            end
        end

        // Merge stored bits with live read-only status bits.
        always_comb begin
            view[gi] = (store_q & ~RO) | (status_in[gi*DATA_W +: DATA_W] & RO);
            reg_q[gi*DATA_W +: DATA_W] = view[gi];
        end
    end

    // Select the addressed register; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_data = view[i];
            end
        end
    end

endmodule

// File: rtl/nibble_ctl_port.sv
// Module: nibble_ctl_port
// Top of the serial nibble register control port: input synchronisers,
// frame sequencer and register bank.
// Assumes: each sclk phase lasts at least SYNC_STAGES+2 clk cycles;
// the output pad is tri-stated outside using sdo_oe.
module nibble_ctl_port #(
    parameter int                         NUM_REGS    = 7,
    parameter int                         ADDR_W      = 3,
    parameter int                         DATA_W      = 4,
    parameter int                         SYNC_STAGES = 2,
    parameter logic [NUM_REGS*DATA_W-1:0] RO_MASK     = 28'hFC0_0000,
    parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL     = 28'h00A_53C1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       csn,
    input  logic                       sclk,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_oe,
    input  logic [NUM_REGS*DATA_W-1:0] status_in,
    output logic [NUM_REGS*DATA_W-1:0] reg_q
);

    logic              csn_s, csn_rise, csn_fall;
    logic              sclk_s, sclk_rise, sclk_fall;
    logic              sdi_s, sdi_rise, sdi_fall;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    scp_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_sync_csn (
        .clk(clk), .rst_n(rst_n), .din(csn),
        .dout(csn_s), .rise(csn_rise), .fall(csn_fall)
    );

    scp_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) i_sync_sclk (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .dout(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
    );

    scp_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) i_sync_sdi (
        .clk(clk), .rst_n(rst_n), .din(sdi),
        .dout(sdi_s), .rise(sdi_rise), .fall(sdi_fall)
    );

    scp_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
        .clk(clk), .rst_n(rst_n),
        .csn_s(csn_s), .csn_fall(csn_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sdi_s(sdi_s), .rd_data(rd_data),
        .addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    scp_nibble_bank #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .RO_MASK(RO_MASK), .RST_VAL(RST_VAL)
    ) i_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .addr(wr_addr), .wr_data(wr_data),
        .status_in(status_in), .rd_data(rd_data), .reg_q(reg_q)
    );

endmodule

// File: rtl/scp_port_checker.sv
// Module: scp_port_checker
// Protocol assertions for nibble_ctl_port, attached with bind below.
// Assumes: signals are taken from the top's internal nets by name.
module scp_port_checker #(
    parameter int                         NUM_REGS = 7,
    parameter int                         ADDR_W   = 3,
    parameter int                         DATA_W   = 4,
    parameter logic [NUM_REGS*DATA_W-1:0] RO_MASK  = '0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       csn_s,
    input logic                       sclk_fall,
    input logic                       sdo_oe,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [NUM_REGS*DATA_W-1:0] reg_q
);

    localparam logic [NUM_REGS*DATA_W-1:0] WMASK = ~RO_MASK;

    AST_OE_DROPS_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !sdo_oe);                                           // R8

    AST_OE_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sclk_fall));                          // R3

    AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sdo_oe);                                           // R4

    AST_WRITE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !csn_s);                                            // R2

    AST_SINGLE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);                                            // R10

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_q & WMASK));                           // R5

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> $stable(reg_q & WMASK)); // R7

endmodule

bind nibble_ctl_port scp_port_checker #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RO_MASK(RO_MASK)
) i_scp_port_checker (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sclk_fall(sclk_fall),
    .sdo_oe(sdo_oe), .wr_en(wr_en), .wr_addr(wr_addr), .reg_q(reg_q)
);

// File: tb/test_nibble_ctl_port.sv
// Bench for nibble_ctl_port: exhaustive write/read sweep, aborts,
// extra clocks and read-only masking against an arithmetic model.
module test_nibble_ctl_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;   // system clocks per sclk phase
    localparam int NR         = 7;
    localparam int DW         = 4;
    localparam logic [NR*DW-1:0] RO  = 28'hFC0_0000;
    localparam logic [NR*DW-1:0] RV  = 28'h00A_53C1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [NR*DW-1:0] status_in = 28'h3A6_9C5E;
    logic [NR*DW-1:0] reg_q;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] model [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_ctl_port #(.RO_MASK(RO), .RST_VAL(RV)) i_nibble_ctl_port (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in), .reg_q(reg_q)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] view(input int a);
        logic [DW-1:0] ro;
        if (a >= NR) return '0;
        ro = RO[a*DW +: DW];
        return (model[a] & ~ro) | (status_in[a*DW +: DW] & ro);
    endfunction

    function automatic logic [NR*DW-1:0] model_q();
        logic [NR*DW-1:0] q;
        for (int i = 0; i < NR; i++) q[i*DW +: DW] = view(i);
        return q;
    endfunction

    function automatic void model_write(input int a, input logic [DW-1:0] d);
        if (a < NR) model[a] = d & ~RO[a*DW +: DW];
    endfunction

    // One frame: nbits rising edges, then extra edges, then csn high.
    task automatic frame(input logic rd, input logic [2:0] a, input logic [3:0] d,
                         input int nbits, input int extra,
                         output logic [3:0] got, output int oe_err);
        logic [7:0] bits;
        bits = {rd, a, d};
        got = '0;
        oe_err = 0;
        csn = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < nbits; k++) begin
            sdi = (rd && k >= 4) ? ~d[k % 4] : bits[7-k];
            wait_clk(HALF);
            if (sdo_oe !== (rd && k >= 4)) oe_err++;
            if (rd && k >= 4) got[7-k] = sdo;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        for (int e = 0; e < extra; e++) begin
            sdi = 1'b1;
            wait_clk(HALF);
            if (sdo_oe !== 1'b0) oe_err++;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        if (nbits == 8 && sdo_oe !== 1'b0) oe_err++;
        csn = 1'b1;
        wait_clk(HALF);
        if (sdo_oe !== 1'b0) oe_err++;
        wait_clk(HALF);
    endtask

    task automatic do_read(input int a, input string req);
        logic [3:0] got;
        int oe_err;
        frame(1'b1, 3'(a), 4'h0, 8, 0, got, oe_err);
        check(req, 32'(got), 32'(view(a)));
        check("R4 read oe window", 32'(oe_err), 32'd0);
        check("R5 read leaves regs", 32'(reg_q), 32'(model_q()));
    endtask

    task automatic do_write(input int a, input logic [3:0] d, input int extra, input string req);
        logic [3:0] got;
        int oe_err;
        frame(1'b0, 3'(a), d, 8, extra, got, oe_err);
        model_write(a, d);
        check(req, 32'(reg_q), 32'(model_q()));
        check("R4 write oe low", 32'(oe_err), 32'd0);
    endtask

    initial begin
        logic [3:0] got;
        int oe_err;
        for (int i = 0; i < NR; i++) model[i] = RV[i*DW +: DW] & ~RO[i*DW +: DW];
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(4);
        check("R9 reset reg_q", 32'(reg_q), 32'(model_q()));
        check("R9 reset sdo_oe", 32'(sdo_oe), 32'd0);
        for (int a = 0; a < 8; a++) do_read(a, "R9 R3 read after reset");

        // R1 R2 R3 R6 R7: every address with every nibble.
        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 16; d++) begin
                do_write(a, 4'(d), 0, "R1 R2 R6 R7 write sweep");
                do_read(a, "R1 R3 R6 R7 read sweep");
            end
        end

        // R6: read-only bits follow live status.
        status_in = 28'h5C3_A1F0;
        wait_clk(4);
        check("R6 reg_q after status change", 32'(reg_q), 32'(model_q()));
        do_read(5, "R6 partial read-only reg");
        do_read(6, "R6 full read-only reg");

        // R8: abort a write after each possible bit count.
        do_write(2, 4'h6, 0, "R2 setup");
        for (int nb = 1; nb < 8; nb++) begin
            frame(1'b0, 3'd2, 4'h9, nb, 0, got, oe_err);
            check("R8 aborted write no update", 32'(reg_q), 32'(model_q()));
            do_read(2, "R8 next frame decodes from bit 0");
        end
        for (int nb = 5; nb < 8; nb++) begin
            frame(1'b1, 3'd1, 4'h0, nb, 0, got, oe_err);
            check("R8 aborted read releases sdo", 32'(oe_err), 32'd0);
        end

        // R10: extra rising edges after bit eight.
        do_write(3, 4'h5, 3, "R10 extra clocks after write");
        do_read(3, "R10 value after extra clocks");
        frame(1'b1, 3'd4, 4'h0, 8, 3, got, oe_err);
        check("R10 read extra clocks data", 32'(got), 32'(view(4)));
        check("R10 read extra clocks oe", 32'(oe_err), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule